// File: doc/BRIEF.md
# Sixteen-Bit Timer/Event Counter with Dual Compare

This block is a free-standing up-counter for timing and event counting. The counter moves forward by one on every cycle where the count-enable input is high. That enable is produced outside the block, either from a prescaler tick or from an external event input. A two-bit mode field picks the behaviour:

- halted;
- free-running with wrap-around;
- restart from zero after a rising edge on the clear pin;
- restart from zero when the count reaches the first compare register.

Two compare registers each drive their own one-cycle interrupt pulse. An overflow flag and a sticky configuration-error flag are also provided, and software clears both by writing a one to them.

Software reaches the block through a simple write port. Address 0 is the control word: mode in bits 1:0, capture enable in bit 2. Address 1 is compare register 0 and address 2 is compare register 1. Address 3 is the status clear: bit 0 clears overflow and bit 1 clears configuration error.

The current count and both compare registers are always visible on output ports. When capture is enabled outside match-restart mode, compare register 0 becomes a capture register. A rising edge on the capture pin then loads it with the count.

Top module: `evt_timer16`

## Requirements
- R1: After reset the count, both compare registers, both interrupts and both flags are zero. Mode 00 holds the count at zero, and any nonzero mode starts counting.
- R2: While the mode is 00, count enables, clear-pin edges and capture-pin edges have no effect. The count stays zero, no interrupt pulses, no capture occurs and no clear is remembered for later.
- R3: The counter keeps no phase of its own. After a start, the count stays at zero until the first count enable, which steps it to 1.
- R4: In mode 01 each count enable adds one to the count, and the count wraps from all-ones to zero.
- R5: In mode 11 with a nonzero compare register 0 value V, the count runs 0..V and returns to zero on the enable that finds it equal to V. That enable also pulses the register-0 interrupt.
- R6: In mode 11 a compare register 0 value of zero sets the sticky configuration-error flag and causes no restart, so the count wraps at all-ones. Writing 1 to status bit 1 clears the flag once the condition is gone.
- R7: A compare value of zero does not fire on the first enable after start. It fires only on the enable that steps the count from zero to one after a wrap.
- R8: Rewriting a compare register to a value below the current count produces no interrupt until the count has wrapped and reached the new value.
- R9: An interrupt output is high for exactly the one cycle after the clock edge whose count enable found the count equal to that compare register.
- R10: In mode 01 the overflow flag sets on the all-ones-to-zero step and stays set until status bit 0 is written with 1.
- R11: In mode 10 a rising edge on the clear pin sets the count to zero at the next count enable, and counting goes on from there. A clear pin held high causes only one clear.
- R12: With control bit 2 set and mode 01 or 10, a capture-pin rising edge copies the count into compare register 0 and pulses its interrupt. Writes to compare register 0 are then ignored.
- R13: Compare register 1 changes only when software writes address 2. Counting and reading the count never load it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 CR0, 2 CR1, 3 status clear) |
| wr_data | input | CNT_W | Write data |
| cnt_en | input | 1 | Count enable (prescaler tick or external event) |
| pin_clr | input | 1 | Clear pin, rising edge restarts the count in mode 10 |
| pin_cap | input | 1 | Capture pin, rising edge loads CR0 when capture is enabled |
| cnt_q | output | CNT_W | Current count |
| cr0_q | output | CNT_W | Compare/capture register 0 |
| cr1_q | output | CNT_W | Compare register 1 |
| irq_cr0 | output | 1 | One-cycle register-0 interrupt |
| irq_cr1 | output | 1 | One-cycle register-1 interrupt |
| ovf_flag | output | 1 | Sticky overflow flag |
| cfg_err | output | 1 | Sticky configuration-error flag |

## Verification
The single-cycle interrupt property assumes that compare values other than zero are used in match-restart mode. It also assumes that capture-pin edges are separated by at least one low cycle, so two events never land on neighbouring edges. The stimulus keeps to this: it writes compare register 0 as zero in mode 11 only during the configuration-error test, and it returns the pins to low between edges. The pins are taken as already synchronous to the clock, and the bench changes them only well after an edge.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Shared types for the timer: mode encoding and register addresses.
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_STOP  = 2'b00,
        MODE_FREE  = 2'b01,
        MODE_EDGE  = 2'b10,
        MODE_MATCH = 2'b11
    } tmr_mode_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CR0  = 2'd1;
    localparam logic [1:0] ADDR_CR1  = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam int CTRL_CAP_BIT = 2;
    localparam int STAT_OVF_BIT = 0;
    localparam int STAT_ERR_BIT = 1;

endpackage

// File: rtl/tmr_edge.sv
`timescale 1ns/1ps
// Rising-edge detector for one pin.
// Assumes the pin is already synchronous to clk; rise is combinational
// and valid in the cycle the pin is first seen high.
module tmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic prev_q;

    // Remember the pin level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin;
    end

    assign rise = pin & ~prev_q;
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
// Counter core: count register, restart logic per mode, arming after
// start, overflow and configuration-error flags.
// Assumes cnt_en is a one-cycle-wide tick; it does not reset any phase.
module tmr_core
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tmr_mode_e     mode,
    input  logic          cnt_en,
    input  logic          clr_rise,
    input  logic [W-1:0]  cr0,
    input  logic          ovf_clr,
    input  logic          err_clr,
    output logic [W-1:0]  cnt,
    output logic          armed,
    output logic          ovf,
    output logic          cfg_err
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic         run;
    logic         pend_q;
    logic         bad_cfg;
    logic [W-1:0] cnt_nxt;

    assign run     = (mode != MODE_STOP);
    assign bad_cfg = (mode == MODE_MATCH) && (cr0 == '0);

    // Pick the value the count takes on an enable.
    always_comb begin
        if (mode == MODE_EDGE && (pend_q || clr_rise))
            cnt_nxt = '0;
        else if (mode == MODE_MATCH && !bad_cfg && cnt == cr0)
            cnt_nxt = '0;
        else
            cnt_nxt = cnt + 1'b1;
    end

    // Count, arming and pending-clear state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            armed  <= 1'b0;
            pend_q <= 1'b0;
        end else if (!run) begin
            cnt    <= '0;
            armed  <= 1'b0;
            pend_q <= 1'b0;
        end else if (cnt_en) begin
            cnt    <= cnt_nxt;
            armed  <= 1'b1;
            pend_q <= 1'b0;
        end else if (mode == MODE_EDGE && clr_rise) begin
            pend_q <= 1'b1;
        end
    end

    // Sticky overflow flag; a new overflow wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf <= 1'b0;
        else if (mode == MODE_FREE && cnt_en && cnt == CNT_MAX)
            ovf <= 1'b1;
        else if (ovf_clr)
            ovf <= 1'b0;
    end

    // Sticky configuration-error flag for a zero restart value.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_err <= 1'b0;
        else if (bad_cfg) cfg_err <= 1'b1;
        else if (err_clr) cfg_err <= 1'b0;
    end
endmodule

// File: rtl/tmr_cmp.sv
`timescale 1ns/1ps
// One compare unit: registered one-cycle interrupt on a match seen at
// a count enable, plus an extra pulse request (capture event).
// Assumes armed is low until the first enable after a start.
module tmr_cmp #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         run,
    input  logic         armed,
    input  logic         cmp_en,
    input  logic         extra_pulse,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp_val,
    output logic         irq
);
    logic hit;

    assign hit = run && cnt_en && armed && cmp_en && (cnt == cmp_val);

    // Register the interrupt so it lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= hit || extra_pulse;
    end
endmodule

// File: rtl/evt_timer16.sv
`timescale 1ns/1ps
// Timer/event counter top: control and compare registers, pin edge
// detection, counter core and two compare units.
// Assumes pins are synchronous to clk and wr_data is at least 3 bits.
module evt_timer16
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             cnt_en,
    input  logic             pin_clr,
    input  logic             pin_cap,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cr0_q,
    output logic [CNT_W-1:0] cr1_q,
    output logic             irq_cr0,
    output logic             irq_cr1,
    output logic             ovf_flag,
    output logic             cfg_err
);
    localparam int N_CMP = 2;

    tmr_mode_e        mode_q;
    logic             cap_q;
    logic             run;
    logic             cap_active;
    logic             cap_evt;
    logic             armed;
    logic [1:0]       pins;
    logic [1:0]       rises;
    logic [CNT_W-1:0] cr_val [N_CMP];
    logic [N_CMP-1:0] cmp_en;
    logic [N_CMP-1:0] extra;
    logic [N_CMP-1:0] irq;
    logic             ovf_clr;
    logic             err_clr;

    assign run        = (mode_q != MODE_STOP);
    assign cap_active = cap_q && (mode_q != MODE_MATCH);
    assign cap_evt    = cap_active && run && rises[1];
    assign ovf_clr    = wr_en && wr_addr == ADDR_STAT && wr_data[STAT_OVF_BIT];
    assign err_clr    = wr_en && wr_addr == ADDR_STAT && wr_data[STAT_ERR_BIT];

    // Control word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_STOP;
            cap_q  <= 1'b0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            mode_q <= tmr_mode_e'(wr_data[1:0]);
            cap_q  <= wr_data[CTRL_CAP_BIT];
        end
    end

    // Register 0: capture has priority; software writes blocked in capture.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cr0_q <= '0;
        else if (cap_evt)
            cr0_q <= cnt_q;
        else if (wr_en && wr_addr == ADDR_CR0 && !cap_active)
            cr0_q <= wr_data;
    end

    // Register 1: loaded only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cr1_q <= '0;
        else if (wr_en && wr_addr == ADDR_CR1) cr1_q <= wr_data;
    end

    assign pins = {pin_cap, pin_clr};

    generate
        for (genvar p = 0; p < 2; p++) begin : g_pin
            tmr_edge u_edge (
                .clk  (clk),
                .rst_n(rst_n),
                .pin  (pins[p]),
                .rise (rises[p])
            );
        end
    endgenerate

    tmr_core #(.W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_q),
        .cnt_en  (cnt_en),
        .clr_rise(rises[0]),
        .cr0     (cr0_q),
        .ovf_clr (ovf_clr),
        .err_clr (err_clr),
        .cnt     (cnt_q),
        .armed   (armed),
        .ovf     (ovf_flag),
        .cfg_err (cfg_err)
    );

    assign cr_val[0] = cr0_q;
    assign cr_val[1] = cr1_q;
    assign cmp_en    = {1'b1, ~cap_active};
    assign extra     = {1'b0, cap_evt};

    generate
        for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
            tmr_cmp #(.W(CNT_W)) u_cmp (
                .clk        (clk),
                .rst_n      (rst_n),
                .cnt_en     (cnt_en),
                .run        (run),
                .armed      (armed),
                .cmp_en     (cmp_en[c]),
                .extra_pulse(extra[c]),
                .cnt        (cnt_q),
                .cmp_val    (cr_val[c]),
                .irq        (irq[c])
            );
        end
    endgenerate

    assign irq_cr0 = irq[0];
    assign irq_cr1 = irq[1];
endmodule

// File: rtl/evt_timer16_chk.sv
`timescale 1ns/1ps
// Property checker for evt_timer16, attached with bind below.
module evt_timer16_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   mode,
    input logic         cnt_en,
    input logic         wr_en,
    input logic [1:0]   wr_addr,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] cr0_q,
    input logic [W-1:0] cr1_q,
    input logic         irq0,
    input logic         irq1,
    input logic         ovf,
    input logic         err
);
    assert_stop_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (cnt_q == '0));

    assert_stop_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (!irq0 && !irq1));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && !cnt_en) |=> $stable(cnt_q));

    assert_free_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && cnt_en) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

    assert_match_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && cnt_en && cr0_q != '0 && cnt_q == cr0_q) |=> (cnt_q == '0));

    assert_bad_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && cr0_q == '0) |=> err);

    assert_irq0_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq0 |=> !irq0);

    assert_irq1_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq1 |=> !irq1);

    assert_ovf_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> ($past(cnt_q) == {W{1'b1}}));

    assert_cr1_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 2'd2) |=> $stable(cr1_q));
endmodule

bind evt_timer16 evt_timer16_chk #(.W(CNT_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode_q),
    .cnt_en (cnt_en),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .cnt_q  (cnt_q),
    .cr0_q  (cr0_q),
    .cr1_q  (cr1_q),
    .irq0   (irq_cr0),
    .irq1   (irq_cr1),
    .ovf    (ovf_flag),
    .err    (cfg_err)
);

// File: tb/evt_timer16_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps an 8-bit configuration of the timer.
module evt_timer16_tb_top;
    localparam int W   = 8;
    localparam int MOD = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         cnt_en = 1'b0;
    logic         pin_clr = 1'b0;
    logic         pin_cap = 1'b0;
    logic [W-1:0] cnt_q, cr0_q, cr1_q;
    logic         irq_cr0, irq_cr1, ovf_flag, cfg_err;

    int n_chk  = 0;
    int n_fail = 0;
    int irq_seen = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    evt_timer16 #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_en(cnt_en), .pin_clr(pin_clr),
        .pin_cap(pin_cap), .cnt_q(cnt_q), .cr0_q(cr0_q), .cr1_q(cr1_q),
        .irq_cr0(irq_cr0), .irq_cr1(irq_cr1), .ovf_flag(ovf_flag),
        .cfg_err(cfg_err)
    );

    always @(posedge clk) if (irq_cr0 || irq_cr1) irq_seen++;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic en);
        cnt_en = en;
        @(posedge clk); #2;
        cnt_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int seen0;
        int hits;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        step(1'b0);
        // R1: reset state
        chk("R1 cnt", cnt_q, 0);
        chk("R1 cr0", cr0_q, 0);
        chk("R1 cr1", cr1_q, 0);
        chk("R1 irq", irq_cr0 + irq_cr1, 0);
        chk("R1 flags", ovf_flag + cfg_err, 0);

        // R2: halted, stimulus ignored
        seen0 = irq_seen;
        for (int i = 0; i < 6; i++) begin
            pin_clr = i[0]; pin_cap = i[0];
            step(1'b1);
        end
        pin_clr = 0; pin_cap = 0;
        step(1'b0);
        chk("R2 cnt held", cnt_q, 0);
        chk("R2 no irq", irq_seen - seen0, 0);
        chk("R2 no capture", cr0_q, 0);

        // R3: start waits for first enable
        wr(2'd0, 1);
        for (int i = 0; i < 3; i++) step(1'b0);
        chk("R3 idle after start", cnt_q, 0);
        step(1'b1);
        chk("R3 first enable", cnt_q, 1);

        // R4/R7/R9/R10: free-run sweep over CR1 values, CR0 = 0
        for (int k = 0; k < 16; k++) begin
            int kv;
            kv = k * 17;
            wr(2'd0, 0);
            wr(2'd1, 0);
            wr(2'd2, kv);
            wr(2'd3, 1);
            wr(2'd0, 1);
            for (int i = 1; i <= MOD + 44; i++) begin
                int pre;
                pre = (i - 1) % MOD;
                step(1'b1);
                chk("R4 count", cnt_q, i % MOD);
                chk("R7 zero compare", irq_cr0, (pre == 0 && i > 1) ? 1 : 0);
                chk("R9 cr1 pulse", irq_cr1, (pre == kv && i > 1) ? 1 : 0);
                if (i == MOD - 1) chk("R10 no ovf yet", ovf_flag, 0);
                if (i == MOD)     chk("R10 ovf set", ovf_flag, 1);
            end
            step(1'b0);
            chk("R9 pulse ends", irq_cr0 + irq_cr1, 0);
            chk("R10 ovf sticky", ovf_flag, 1);
            wr(2'd3, 1);
            chk("R10 ovf cleared", ovf_flag, 0);
        end

        // R5: restart on CR0 match
        for (int v = 1; v < MOD; v = v * 3 + 1) begin
            wr(2'd0, 0);
            wr(2'd1, v);
            wr(2'd0, 3);
            for (int i = 1; i <= 3 * (v + 1) + 2; i++) begin
                int pre;
                pre = (i - 1) % (v + 1);
                step(1'b1);
                chk("R5 count", cnt_q, i % (v + 1));
                chk("R5 irq", irq_cr0, (pre == v) ? 1 : 0);
            end
            chk("R5 no error", cfg_err, 0);
        end

        // R6: zero restart value is a configuration error
        wr(2'd0, 0);
        wr(2'd1, 0);
        wr(2'd0, 3);
        step(1'b0);
        chk("R6 error set", cfg_err, 1);
        for (int i = 0; i < 5; i++) step(1'b1);
        chk("R6 no clear at zero", cnt_q, 5);
        for (int i = 0; i < MOD - 5; i++) step(1'b1);
        chk("R6 wraps at max", cnt_q, 0);
        wr(2'd0, 1);
        chk("R6 sticky", cfg_err, 1);
        wr(2'd3, 2);
        chk("R6 cleared", cfg_err, 0);

        // R8: lowered compare waits for a wrap
        wr(2'd0, 0);
        wr(2'd2, 100);
        wr(2'd0, 1);
        for (int i = 0; i < 150; i++) step(1'b1);
        chk("R8 count", cnt_q, 150);
        wr(2'd2, 50);
        hits = 0;
        for (int j = 1; j <= (MOD - 150) + 50 + 1; j++) begin
            step(1'b1);
            if (j < (MOD - 150) + 51) hits += irq_cr1;
        end
        chk("R8 no early match", hits, 0);
        chk("R8 match after wrap", irq_cr1, 1);

        // R11: clear pin in edge-restart mode
        wr(2'd0, 0);
        wr(2'd0, 2);
        for (int i = 0; i < 10; i++) step(1'b1);
        pin_clr = 1'b1;
        step(1'b0);
        chk("R11 waits for enable", cnt_q, 10);
        step(1'b1);
        chk("R11 cleared", cnt_q, 0);
        step(1'b1);
        chk("R11 held high once", cnt_q, 1);
        pin_clr = 1'b0;
        step(1'b1);
        chk("R11 continues", cnt_q, 2);
        // R2: edge while halted is not remembered
        wr(2'd0, 0);
        pin_clr = 1'b1;
        step(1'b0);
        pin_clr = 1'b0;
        wr(2'd0, 2);
        step(1'b1);
        chk("R2 stopped edge dropped", cnt_q, 1);

        // R12/R13: capture on pin edge
        wr(2'd0, 0);
        wr(2'd2, 123);
        wr(2'd0, 5);
        for (int i = 0; i < 20; i++) step(1'b1);
        pin_cap = 1'b1;
        step(1'b0);
        chk("R12 captured", cr0_q, 20);
        chk("R12 irq", irq_cr0, 1);
        step(1'b0);
        chk("R9 capture pulse ends", irq_cr0, 0);
        pin_cap = 1'b0;
        wr(2'd1, 77);
        chk("R12 write ignored", cr0_q, 20);
        wr(2'd0, 4);
        pin_cap = 1'b1;
        step(1'b0);
        pin_cap = 1'b0;
        chk("R2 no capture halted", cr0_q, 20);
        chk("R13 cr1 held", cr1_q, 123);
        wr(2'd2, 9);
        chk("R13 cr1 write", cr1_q, 9);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule